// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide host side of a three-channel programmable interval timer. A host reaches it through a 2-bit address, an 8-bit write bus, an 8-bit read bus and separate read and write strobes. Address 3 takes control bytes. Addresses 0, 1 and 2 are the data ports of the three channels. The counting cores sit outside the block. Each core supplies a live 16-bit count and an output level. Each core receives a one-cycle load pulse with a 16-bit load value.

Each control byte names a channel in its top two bits. The byte can program that channel's access mode, counting mode and BCD flag. It can instead snapshot the channel's count. With the channel field set to 3, it becomes a read-back command that latches count and status on any group of channels in one write. The block then sequences the low and high bytes of every count read and count write, following each channel's access mode. It keeps a separate byte toggle for reads and for writes. Any held status byte is returned ahead of a held count.

`rdData` is combinational from the address and the held state. All state changes, including the side effects of a read, happen at the rising clock edge while a strobe is high. The load pulse and load value are registered and appear one cycle after the write that completes a value.

Top module: `timer_host_if`

## Requirements
- R1: A write to address 3 with bits 7:6 below 3 and bits 5:4 non-zero programs that channel. It sets the access mode from bits 5:4 (1 = low byte only, 2 = high byte only, 3 = low then high), the counting mode from bits 3:1 and the BCD flag from bit 0, and it returns both byte toggles of the channel to the low byte.
- R2: A write to address 3 with bits 5:4 equal to 0 snapshots the live count of the channel in bits 7:6. It leaves that channel's modes and flag unchanged.
- R3: A write to address 3 with bits 7:6 equal to 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low latches the count of each selected channel, and bit 4 low latches its status.
- R4: A latched status byte holds the output level in bit 7, 0 in bit 6, the access mode in bits 5:4, the counting mode in bits 3:1 and the BCD flag in bit 0, all taken when the latch is made.
- R5: A latch command does not replace a count or status that is still held. The held value remains until it has been fully read.
- R6: A data-port read returns the held status and releases it if one is held. Otherwise it returns a held count byte if one is held, and otherwise a byte of the live count.
- R7: A held count is read according to the access mode at latch time. Low-only mode gives one read of the low byte. High-only mode gives one read of the high byte. Word mode gives the low byte and then the high byte. The latch is released after its last byte.
- R8: In low-only mode a data write loads {8'h00, byte}, and in high-only mode it loads {byte, 8'h00`}. The load pulse on that channel's bit of `loadStrobe`, with `loadValue`, appears in the cycle after the write.
- R9: In word mode the first data write is held as the low byte without any load. The second write loads {second, first}.
- R10: Unlatched reads in word mode alternate between the low byte and the high byte of the live count. The read toggle moves independently of the write toggle.
- R11: After reset every channel is in low-only access mode with counting mode 0 and BCD clear. No latches are held, and both toggles point at the low byte.
- R12: A read at address 3 returns 0 and changes no state. A write at address 3 never causes a load pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Port address: 0 to 2 are channel data ports, 3 is the control port |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write byte |
| rdEn | input | 1 | Read strobe; the read's side effects occur at the clock edge |
| rdData | output | 8 | Read byte for the current address |
| liveCount | input | 48 | Live counts from the cores, channel n in bits 16n+15:16n |
| outLevel | input | 3 | Output level of each core |
| loadStrobe | output | 3 | One-cycle load pulse, one bit per channel |
| loadValue | output | 16 | Value to load, valid while a loadStrobe bit is high |

## Verification
On every cycle the assertions check that at most one load pulse is active. They also check that each pulse follows a data-port write to its own channel, that a control write is never followed by a pulse, and that address 3 reads as zero. Latch ordering, the no-relatch rule, the status-before-count priority, the status byte layout and the independence of the two byte toggles depend on sequences of commands. Only the bench's scenarios show these, by comparing against its reference model on every clock.

// File: rtl/timer_if_pkg.sv
package timer_if_pkg;
  localparam int NUM_CH  = 3;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 2 * BYTE_W;
  localparam int MODE_W  = 3;
  localparam int ADDR_W  = 2;
  localparam int PORTS   = 1 << ADDR_W;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LOW  = 2'd1,
    ACC_HIGH = 2'd2,
    ACC_WORD = 2'd3
  } accMode_t;

  typedef struct packed {
    logic [NUM_CH-1:0] setMode;
    logic [NUM_CH-1:0] latchCount;
    logic [NUM_CH-1:0] latchStatus;
    logic [NUM_CH-1:0] dataWrite;
    logic [NUM_CH-1:0] dataRead;
    accMode_t          newAcc;
    logic [MODE_W-1:0] newMode;
    logic              newBcd;
    logic [BYTE_W-1:0] wrByte;
  } chanCmd_t;
endpackage

// File: rtl/timer_if_ctrl.sv
module timer_if_ctrl
  import timer_if_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BYTE_W-1:0] wrData,
  output chanCmd_t          cmd
);
  localparam logic [ADDR_W-1:0] CTRL_PORT = ADDR_W'(PORTS - 1);

  logic              isCtrl;
  logic [PORTS-1:0]  portHot;
  logic [PORTS-1:0]  selHot;
  logic              isReadBack;
  logic              isCntLatch;

  assign isCtrl     = (addr == CTRL_PORT);
  assign portHot    = PORTS'(1) << addr;
  assign selHot     = PORTS'(1) << wrData[7:6];
  assign isReadBack = (wrData[7:6] == CTRL_PORT);
  assign isCntLatch = (wrData[5:4] == ACC_NONE);

  always_comb begin
    cmd         = '0;
    cmd.newAcc  = accMode_t'(wrData[5:4]);
    cmd.newMode = wrData[3:1];
    cmd.newBcd  = wrData[0];
    cmd.wrByte  = wrData;
    if (wrEn && isCtrl) begin
      if (isReadBack) begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (wrData[i+1]) begin
            cmd.latchCount[i]  = ~wrData[5];
            cmd.latchStatus[i] = ~wrData[4];
          end
        end
      end else if (isCntLatch) begin
        cmd.latchCount = selHot[NUM_CH-1:0];
      end else begin
        cmd.setMode = selHot[NUM_CH-1:0];
      end
    end
    if (wrEn && !isCtrl) cmd.dataWrite = portHot[NUM_CH-1:0];
    if (rdEn && !isCtrl) cmd.dataRead  = portHot[NUM_CH-1:0];
  end
endmodule

// File: rtl/timer_if_dpath.sv
module timer_if_dpath
  import timer_if_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  chanCmd_t                 cmd,
  input  logic [ADDR_W-1:0]        rdSel,
  input  logic [NUM_CH*CNT_W-1:0]  liveCount,
  input  logic [NUM_CH-1:0]        outLevel,
  output logic [BYTE_W-1:0]        rdData,
  output logic [NUM_CH-1:0]        loadStrobe,
  output logic [CNT_W-1:0]         loadValue
);
  logic [BYTE_W-1:0] chanByte [PORTS];
  logic [CNT_W-1:0]  chanLoad [NUM_CH];

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : gChan
      accMode_t          acc;
      logic [MODE_W-1:0] mode;
      logic              bcd;
      logic              rdTog;
      logic              wrTog;
      logic [BYTE_W-1:0] lowHold;
      accMode_t          cntHeld;
      logic [CNT_W-1:0]  cntVal;
      logic              statHeld;
      logic [BYTE_W-1:0] statVal;
      logic [CNT_W-1:0]  live;

      assign live = liveCount[g*CNT_W +: CNT_W];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          acc           <= ACC_LOW;
          mode          <= '0;
          bcd           <= 1'b0;
          rdTog         <= 1'b0;
          wrTog         <= 1'b0;
          lowHold       <= '0;
          cntHeld       <= ACC_NONE;
          cntVal        <= '0;
          statHeld      <= 1'b0;
          statVal       <= '0;
          loadStrobe[g] <= 1'b0;
          chanLoad[g]   <= '0;
        end else begin
          loadStrobe[g] <= 1'b0;
          if (cmd.setMode[g]) begin
            acc   <= cmd.newAcc;
            mode  <= cmd.newMode;
            bcd   <= cmd.newBcd;
            rdTog <= 1'b0;
            wrTog <= 1'b0;
          end
          if (cmd.latchCount[g] && cntHeld == ACC_NONE) begin
            cntVal  <= live;
            cntHeld <= acc;
          end
          if (cmd.latchStatus[g] && !statHeld) begin
            statVal  <= {outLevel[g], 1'b0, acc, mode, bcd};
            statHeld <= 1'b1;
          end
          if (cmd.dataWrite[g]) begin
            unique case (acc)
              ACC_HIGH: begin
                chanLoad[g]   <= {cmd.wrByte, {BYTE_W{1'b0}}};
                loadStrobe[g] <= 1'b1;
              end
              ACC_WORD: begin
                if (!wrTog) begin
                  lowHold <= cmd.wrByte;
                end else begin
                  chanLoad[g]   <= {cmd.wrByte, lowHold};
                  loadStrobe[g] <= 1'b1;
                end
                wrTog <= ~wrTog;
              end
              default: begin
                chanLoad[g]   <= {{BYTE_W{1'b0}}, cmd.wrByte};
                loadStrobe[g] <= 1'b1;
              end
            endcase
          end
          if (cmd.dataRead[g]) begin
            if (statHeld)                  statHeld <= 1'b0;
            else if (cntHeld == ACC_WORD)  cntHeld  <= ACC_HIGH;
            else if (cntHeld != ACC_NONE)  cntHeld  <= ACC_NONE;
            else if (acc == ACC_WORD)      rdTog    <= ~rdTog;
          end
        end
      end

      always_comb begin
        if (statHeld)
          chanByte[g] = statVal;
        else if (cntHeld == ACC_HIGH)
          chanByte[g] = cntVal[CNT_W-1:BYTE_W];
        else if (cntHeld != ACC_NONE)
          chanByte[g] = cntVal[BYTE_W-1:0];
        else if (acc == ACC_HIGH || (acc == ACC_WORD && rdTog))
          chanByte[g] = live[CNT_W-1:BYTE_W];
        else
          chanByte[g] = live[BYTE_W-1:0];
      end
    end

    for (g = NUM_CH; g < PORTS; g++) begin : gCtrlPort
      assign chanByte[g] = '0;
    end
  endgenerate

  assign rdData = chanByte[rdSel];

  always_comb begin
    loadValue = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (loadStrobe[i]) loadValue = loadValue | chanLoad[i];
  end
endmodule

// File: rtl/timer_host_if.sv
module timer_host_if
  import timer_if_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wrEn,
  input  logic [BYTE_W-1:0]        wrData,
  input  logic                     rdEn,
  output logic [BYTE_W-1:0]        rdData,
  input  logic [NUM_CH*CNT_W-1:0]  liveCount,
  input  logic [NUM_CH-1:0]        outLevel,
  output logic [NUM_CH-1:0]        loadStrobe,
  output logic [CNT_W-1:0]         loadValue
);
  chanCmd_t cmd;

  timer_if_ctrl ctrl_i (
    .addr   (addr),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .wrData (wrData),
    .cmd    (cmd)
  );

  timer_if_dpath dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .rdSel      (addr),
    .liveCount  (liveCount),
    .outLevel   (outLevel),
    .rdData     (rdData),
    .loadStrobe (loadStrobe),
    .loadValue  (loadValue)
  );
endmodule

// File: rtl/timer_host_if_chk.sv
module timer_host_if_chk
  import timer_if_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [BYTE_W-1:0] rdData,
  input logic [NUM_CH-1:0] loadStrobe
);
  localparam logic [ADDR_W-1:0] CTRL_PORT = ADDR_W'(PORTS - 1);

  assert_one_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadStrobe));

  assert_ctrl_no_load_R12: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == CTRL_PORT) |=> (loadStrobe == '0));

  assert_ctrl_reads_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    (addr == CTRL_PORT) |-> (rdData == '0));

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : gSrc
      assert_load_source_R9: assert property (@(posedge clk) disable iff (!rstN)
        loadStrobe[g] |-> ($past(wrEn) && $past(addr) == ADDR_W'(g)));
    end
  endgenerate
endmodule

bind timer_host_if timer_host_if_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .addr       (addr),
  .wrEn       (wrEn),
  .rdData     (rdData),
  .loadStrobe (loadStrobe)
);

// File: tb/tb_timer_host_if.sv
module tb_timer_host_if;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = 8'd0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic [47:0] liveCount = 48'd0;
  logic [2:0]  outLevel = 3'd0;
  logic [2:0]  loadStrobe;
  logic [15:0] loadValue;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  timer_host_if dut (.*);

  // reference model
  int acc [3];
  int md [3];
  int bcdF [3];
  int rdT [3];
  int wrT [3];
  int lowB [3];
  bit statH [3];
  int statV [3];
  logic [7:0] latQ [3][$];
  int expLs = 0;
  int expLv = 0;

  function automatic int liveOf(int c);
    return int'(liveCount[c*16 +: 16]);
  endfunction

  function automatic int expRd(int a);
    int v;
    if (a == 3) return 0;
    if (statH[a]) return statV[a];
    if (latQ[a].size() > 0) return int'(latQ[a][0]);
    v = liveOf(a);
    if (acc[a] == 2 || (acc[a] == 3 && rdT[a] == 1)) return (v >> 8) & 255;
    return v & 255;
  endfunction

  task automatic modelReset();
    for (int c = 0; c < 3; c++) begin
      acc[c] = 1; md[c] = 0; bcdF[c] = 0; rdT[c] = 0; wrT[c] = 0;
      lowB[c] = 0; statH[c] = 0; statV[c] = 0; latQ[c].delete();
    end
    expLs = 0; expLv = 0;
  endtask

  task automatic latchCnt(int c);
    int v;
    if (latQ[c].size() != 0) return;
    v = liveOf(c);
    if (acc[c] != 2) latQ[c].push_back(8'(v & 255));
    if (acc[c] != 1) latQ[c].push_back(8'((v >> 8) & 255));
  endtask

  task automatic modelEdge(bit w, bit r, int a, int d);
    int ch;
    expLs = 0; expLv = 0;
    if (w && a == 3) begin
      ch = (d >> 6) & 3;
      if (ch == 3) begin
        for (int c = 0; c < 3; c++) begin
          if (((d >> (c + 1)) & 1) == 1) begin
            if (((d >> 5) & 1) == 0) latchCnt(c);
            if (((d >> 4) & 1) == 0 && !statH[c]) begin
              statH[c] = 1;
              statV[c] = (int'(outLevel[c]) << 7) | (acc[c] << 4) | (md[c] << 1) | bcdF[c];
            end
          end
        end
      end else if (((d >> 4) & 3) == 0) begin
        latchCnt(ch);
      end else begin
        acc[ch] = (d >> 4) & 3; md[ch] = (d >> 1) & 7; bcdF[ch] = d & 1;
        rdT[ch] = 0; wrT[ch] = 0;
      end
    end else if (w) begin
      if (acc[a] == 1) begin expLs = 1 << a; expLv = d; end
      else if (acc[a] == 2) begin expLs = 1 << a; expLv = d << 8; end
      else if (wrT[a] == 0) begin lowB[a] = d; wrT[a] = 1; end
      else begin expLs = 1 << a; expLv = (d << 8) | lowB[a]; wrT[a] = 0; end
    end
    if (r && a != 3) begin
      if (statH[a]) statH[a] = 0;
      else if (latQ[a].size() > 0) void'(latQ[a].pop_front());
      else if (acc[a] == 3) rdT[a] = 1 - rdT[a];
    end
  endtask

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit w, bit r, int a, int d);
    @(negedge clk);
    wrEn = w; rdEn = r; addr = 2'(a); wrData = 8'(d);
    #1;
    check({tag, " rdData"}, int'(rdData), expRd(a));
    check({tag, " loadStrobe"}, int'(loadStrobe), expLs);
    if (expLs != 0) check({tag, " loadValue"}, int'(loadValue), expLv);
    @(posedge clk);
    modelEdge(w, r, a, d);
  endtask

  task automatic wr(string tag, int a, int d); cyc(tag, 1, 0, a, d); endtask
  task automatic rd(string tag, int a);        cyc(tag, 0, 1, a, 0); endtask
  task automatic idle(string tag, int a);      cyc(tag, 0, 0, a, 0); endtask

  task automatic setLive(int c, int v);
    @(negedge clk);
    liveCount[c*16 +: 16] = 16'(v);
  endtask

  initial begin
    #(8 * 5000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    modelReset();
    liveCount = {16'h0F0F, 16'hABCD, 16'h1234};
    outLevel = 3'b101;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R11: reset state, low-only live reads
    idle("R11 idle", 0);
    rd("R11 live low ch0", 0);
    rd("R11 live low ch1", 1);
    // R3/R4: read-back of status on all channels
    wr("R3 readback status", 3, 8'hEE);
    rd("R4 status ch0", 0);
    rd("R4 status ch1", 1);
    rd("R4 status ch2", 2);
    // R1: program ch1 word, mode 2, BCD
    wr("R1 ctrl ch1", 3, 8'h75);
    wr("R1 readback ch1", 3, 8'hE4);
    rd("R1 status ch1", 1);
    // R9: word write
    wr("R9 first byte", 1, 8'h78);
    wr("R9 second byte", 1, 8'h56);
    idle("R9 load", 1);
    // R10: alternating reads, independent toggles
    rd("R10 read lo", 1);
    rd("R10 read hi", 1);
    rd("R10 read lo2", 1);
    wr("R10 write lo", 1, 8'h11);
    rd("R10 read hi2", 1);
    wr("R10 write hi", 1, 8'h22);
    idle("R10 load", 1);
    wr("R10 reprogram", 3, 8'h75);
    rd("R10 toggle reset", 1);
    // R2/R7: counter latch in word mode
    wr("R2 latch ch1", 3, 8'h40);
    setLive(1, 16'h1111);
    rd("R7 word latched lo", 1);
    rd("R7 word latched hi", 1);
    rd("R2 live after latch", 1);
    wr("R2 readback ch1", 3, 8'hE4);
    rd("R2 mode kept", 1);
    // R5: no relatch
    wr("R5 latch ch0", 3, 8'h00);
    setLive(0, 16'h5555);
    wr("R5 latch again", 3, 8'h00);
    rd("R5 old value", 0);
    rd("R7 low released", 0);
    // R8: low and high writes
    wr("R8 ctrl ch2 high", 3, 8'hA0);
    wr("R8 write high", 2, 8'h9A);
    wr("R8 write low", 0, 8'h42);
    idle("R8 load low", 0);
    wr("R7 latch ch2", 3, 8'h80);
    setLive(2, 16'h7000);
    rd("R7 high latched", 2);
    rd("R7 high live", 2);
    // R6: priority status over count over live
    wr("R6 readback both ch0", 3, 8'hC2);
    setLive(0, 16'h6666);
    wr("R5 status no relatch", 3, 8'hE2);
    rd("R6 status first", 0);
    rd("R6 count second", 0);
    rd("R6 live third", 0);
    // R12: control port reads
    rd("R12 read ctrl", 3);
    rd("R12 read ctrl again", 3);
    rd("R12 state unchanged", 1);
    idle("R12 end", 2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule